// File: doc/BRIEF.md
# Processor Card Control and Status Registers

This block is the register file a processor card exposes to its own CPU. Software reaches it over a plain 32-bit register bus made of a word address, a write strobe, a read strobe, write data and combinational read data. It returns fixed identity and status words. It holds two clock-synthesis setting registers behind a 16-bit unlock key, together with SDRAM and init setting words. It also keeps two flag words and a one-bit software interrupt whose IRQ and FIQ masks each drive an output pin. A read-only window describes the fitted memory.

Some board-level effects have no hardware in this block. For the remap select, the status LED and the board reset request, the block only drives control outputs. The clock and voltage settings are register contents and nothing more. The fitted memory size is the `MEM_MB` parameter. It sets the size code in the SDRAM word and the final byte of the description window.

Top module: `board_ctl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000. Words 32 to 35 read 0, and writes to them are accepted and change nothing.
- R2: After reset:
  - word 2 reads 0x01000048 and word 7 reads 0x0007FEFF;
  - word 9 reads 0x112;
  - word 8 reads 0x00011122 ORed with a size code: 0x10 for `MEM_MB` of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise. With the default of 128 it reads 0x0001112E.
- R3: A write to word 5 keeps only data bits 15:0. Word 5 reads back that value, with bit 16 also set while the value is 0xA05F.
- R4: Writes to word 2 and word 7 take effect only while word 5 holds 0xA05F. Otherwise they are dropped.
- R5: Words 8 and 9 are plain read/write registers.
- R6: Writing word 12 ORs the data into the flag word, and writing word 13 clears the bits set in the data. Word 12 reads the flag word. Words 14 and 15 do the same for a second flag word, which word 14 reads.
- R7: Writing word 18 sets IRQ enable bits and writing word 19 clears them. Word 18 reads the IRQ enables. Words 26 and 27 do the same for the FIQ enables, which word 26 reads.
- R8: Writing word 20 with data bit 0 set raises the software interrupt, which is bit 0 of the raw level. Writing word 21 with data bit 0 set lowers it, and other data bits have no effect on either word. Words 17 and 25 read the raw level and word 20 reads its bit 0. Word 16 reads raw AND IRQ enables, and word 24 reads raw AND FIQ enables.
- R9: `irq` is high whenever raw AND IRQ enables is non-zero, and `fiq` is high whenever raw AND FIQ enables is non-zero.
- R10: Words 64 to 95 each read one byte of the memory description table in bits 7:0, with table index equal to the word minus 64. Index 0 is 0x80, index 9 is 0xA0, and index 31 is 0x20 for 128 MB. Words 96 to 127 read 0, and the whole window ignores writes.
- R11: A write to word 3 sets `led` from data bit 0 and `remap_sel` from data bit 2, and word 3 reads those two bits in place. A write with data bit 3 set makes `reset_req` high for exactly the next cycle.
- R12: A read of a word outside the readable set, or a write to a word outside the writable set, reads 0, changes nothing and raises `err` for the following cycle.
  - Readable words: 0-5, 7-9, 12, 14, 16-18, 20, 24-26, 32-35 and 64-127.
  - Writable words: 2, 3, 5, 7-9, 12-15, 18-21, 26, 27 and 32-35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_addr | input | 10 | Register word index |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, used only for error reporting |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `word_addr`, combinational |
| err | output | 1 | One-cycle flag after an access to an unmapped word |
| irq | output | 1 | Masked IRQ request |
| fiq | output | 1 | Masked FIQ request |
| remap_sel | output | 1 | Low-memory remap select |
| led | output | 1 | Status LED drive |
| reset_req | output | 1 | One-cycle board reset request |

## Verification
The assertions assume the bus strobes are never active while reset is high, and that a full-mask clear is a single write. The stimulus only changes inputs on the falling edge and keeps `wr_en` and `rd_en` low during reset. It never raises both strobes in the same cycle, and every write lasts exactly one cycle, so each reset pulse, error flag and set/clear result can be tied to one bus operation.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int DW     = 32;
    localparam int WA     = 10;
    localparam int KEY_W  = 16;

    localparam logic [DW-1:0]    ID_VALUE    = 32'h411A_3001;
    localparam logic [DW-1:0]    STAT_VALUE  = 32'h0010_0000;
    localparam logic [KEY_W-1:0] UNLOCK_KEY  = 16'hA05F;
    localparam logic [DW-1:0]    OSC_INIT    = 32'h0100_0048;
    localparam logic [DW-1:0]    AUX_INIT    = 32'h0007_FEFF;
    localparam logic [DW-1:0]    INIT_INIT   = 32'h0000_0112;
    localparam logic [DW-1:0]    SDRAM_BASE  = 32'h0001_1122;

    localparam logic [WA-1:0] A_ID    = 10'd0;
    localparam logic [WA-1:0] A_PROC  = 10'd1;
    localparam logic [WA-1:0] A_OSC   = 10'd2;
    localparam logic [WA-1:0] A_CTRL  = 10'd3;
    localparam logic [WA-1:0] A_STAT  = 10'd4;
    localparam logic [WA-1:0] A_LOCK  = 10'd5;
    localparam logic [WA-1:0] A_AUX   = 10'd7;
    localparam logic [WA-1:0] A_SDRAM = 10'd8;
    localparam logic [WA-1:0] A_INIT  = 10'd9;
    localparam logic [WA-1:0] A_FLG_S = 10'd12;
    localparam logic [WA-1:0] A_FLG_C = 10'd13;
    localparam logic [WA-1:0] A_NVF_S = 10'd14;
    localparam logic [WA-1:0] A_NVF_C = 10'd15;
    localparam logic [WA-1:0] A_I_MSK = 10'd16;
    localparam logic [WA-1:0] A_I_RAW = 10'd17;
    localparam logic [WA-1:0] A_I_ENS = 10'd18;
    localparam logic [WA-1:0] A_I_ENC = 10'd19;
    localparam logic [WA-1:0] A_SW_S  = 10'd20;
    localparam logic [WA-1:0] A_SW_C  = 10'd21;
    localparam logic [WA-1:0] A_F_MSK = 10'd24;
    localparam logic [WA-1:0] A_F_RAW = 10'd25;
    localparam logic [WA-1:0] A_F_ENS = 10'd26;
    localparam logic [WA-1:0] A_F_ENC = 10'd27;

    typedef struct packed {
        logic remap;
        logic led;
    } ctrl_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [WA-1:0] word;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic [DW-1:0] size_code(input int unsigned mb);
        if (mb >= 256)      return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    function automatic logic [7:0] size_byte(input int unsigned mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] desc_byte(input logic [4:0] idx, input int unsigned mb);
        case (idx)
            5'd0:  return 8'h80;
            5'd1:  return 8'h08;
            5'd2:  return 8'h04;
            5'd3:  return 8'h0B;
            5'd4:  return 8'h09;
            5'd5:  return 8'h01;
            5'd6:  return 8'h40;
            5'd8:  return 8'h02;
            5'd9:  return 8'hA0;
            5'd10: return 8'hA0;
            5'd13: return 8'h08;
            5'd15: return 8'h01;
            5'd16: return 8'h0E;
            5'd17: return 8'h04;
            5'd18: return 8'h1C;
            5'd19: return 8'h01;
            5'd20: return 8'h02;
            5'd21: return 8'h20;
            5'd22: return 8'hC0;
            5'd27: return 8'h30;
            5'd28: return 8'h28;
            5'd29: return 8'h30;
            5'd30: return 8'h28;
            5'd31: return size_byte(mb);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/board_ctl_setclr.sv
module board_ctl_setclr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= INIT;
        else if (set_we) q <= q | d;
        else if (clr_we) q <= q & ~d;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        ($past(set_we) && !$past(rst)) |-> ((q & $past(d)) == $past(d))); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_we) && !$past(set_we) && !$past(rst)) |-> ((q & $past(d)) == '0)); // R6
endmodule

// File: rtl/board_ctl_keyed.sv
module board_ctl_keyed import board_ctl_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_we,
    input  logic             osc_we,
    input  logic             aux_we,
    input  logic [DW-1:0]    wdata,
    output logic [KEY_W-1:0] lock_q,
    output logic [DW-1:0]    osc_q,
    output logic [DW-1:0]    aux_q,
    output logic             unlocked
);
    assign unlocked = (lock_q == UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
            osc_q  <= OSC_INIT;
            aux_q  <= AUX_INIT;
        end else begin
            if (lock_we)             lock_q <= wdata[KEY_W-1:0];
            if (osc_we && unlocked)  osc_q  <= wdata;
            if (aux_we && unlocked)  aux_q  <= wdata;
        end
    end

    AST_OSC_KEYED: assert property (@(posedge clk) disable iff (rst)
        (!$past(unlocked) && !$past(rst)) |-> $stable(osc_q)); // R4
    AST_AUX_KEYED: assert property (@(posedge clk) disable iff (rst)
        (!$past(unlocked) && !$past(rst)) |-> $stable(aux_q)); // R4
endmodule

// File: rtl/board_ctl_intc.sv
module board_ctl_intc import board_ctl_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          ien_set,
    input  logic          ien_clr,
    input  logic          fen_set,
    input  logic          fen_clr,
    input  logic          sw_set,
    input  logic          sw_clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] raw,
    output logic [DW-1:0] ien,
    output logic [DW-1:0] fen,
    output logic          irq,
    output logic          fiq
);
    logic sw_lvl;

    board_ctl_setclr #(.W(DW)) u_ien (
        .clk(clk), .rst(rst), .set_we(ien_set), .clr_we(ien_clr), .d(wdata), .q(ien));
    board_ctl_setclr #(.W(DW)) u_fen (
        .clk(clk), .rst(rst), .set_we(fen_set), .clr_we(fen_clr), .d(wdata), .q(fen));
    board_ctl_setclr #(.W(1)) u_sw (
        .clk(clk), .rst(rst), .set_we(sw_set), .clr_we(sw_clr), .d(wdata[0]), .q(sw_lvl));

    assign raw = {{(DW-1){1'b0}}, sw_lvl};
    assign irq = |(raw & ien);
    assign fiq = |(raw & fen);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        ($past(ien_clr && (wdata == '1)) && !$past(rst)) |-> !irq); // R9
    AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        ($past(fen_clr && (wdata == '1)) && !$past(rst)) |-> !fiq); // R9
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs import board_ctl_pkg::*; #(
    parameter int unsigned MEM_MB = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WA-1:0] word_addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          err,
    output logic          irq,
    output logic          fiq,
    output logic          remap_sel,
    output logic          led,
    output logic          reset_req
);
    localparam logic [DW-1:0] SDRAM_INIT = SDRAM_BASE | size_code(MEM_MB);

    bus_req_t req;
    assign req = '{wr: wr_en, rd: rd_en, word: word_addr, data: wdata};

    logic in_window, volt_hit;
    assign in_window = (req.word[WA-1:6] == 4'b0001);
    assign volt_hit  = (req.word[WA-1:2] == 8'd8);

    function automatic logic wr_hit(input bus_req_t r, input logic [WA-1:0] a);
        return r.wr && (r.word == a);
    endfunction

    logic [KEY_W-1:0] lock_q;
    logic [DW-1:0]    osc_q, aux_q, sdram_q, init_q, flg_q, nvf_q;
    logic [DW-1:0]    raw, ien, fen;
    logic             unlocked;
    ctrl_t            ctrl_q;

    board_ctl_keyed u_keyed (
        .clk(clk), .rst(rst),
        .lock_we(wr_hit(req, A_LOCK)), .osc_we(wr_hit(req, A_OSC)), .aux_we(wr_hit(req, A_AUX)),
        .wdata(req.data), .lock_q(lock_q), .osc_q(osc_q), .aux_q(aux_q), .unlocked(unlocked));

    board_ctl_setclr #(.W(DW)) u_flg (
        .clk(clk), .rst(rst), .set_we(wr_hit(req, A_FLG_S)), .clr_we(wr_hit(req, A_FLG_C)),
        .d(req.data), .q(flg_q));
    board_ctl_setclr #(.W(DW)) u_nvf (
        .clk(clk), .rst(rst), .set_we(wr_hit(req, A_NVF_S)), .clr_we(wr_hit(req, A_NVF_C)),
        .d(req.data), .q(nvf_q));

    board_ctl_intc u_intc (
        .clk(clk), .rst(rst),
        .ien_set(wr_hit(req, A_I_ENS)), .ien_clr(wr_hit(req, A_I_ENC)),
        .fen_set(wr_hit(req, A_F_ENS)), .fen_clr(wr_hit(req, A_F_ENC)),
        .sw_set(wr_hit(req, A_SW_S)), .sw_clr(wr_hit(req, A_SW_C)),
        .wdata(req.data), .raw(raw), .ien(ien), .fen(fen), .irq(irq), .fiq(fiq));

    // read mux and legality decode
    logic rd_ok, wr_ok;
    always_comb begin
        rdata = '0;
        rd_ok = 1'b1;
        if (in_window) begin
            if (!req.word[5]) rdata = {24'b0, desc_byte(req.word[4:0], MEM_MB)};
        end else if (volt_hit) begin
            rdata = '0;
        end else begin
            case (req.word)
                A_ID:    rdata = ID_VALUE;
                A_PROC:  rdata = '0;
                A_OSC:   rdata = osc_q;
                A_CTRL:  rdata = {29'b0, ctrl_q.remap, 1'b0, ctrl_q.led};
                A_STAT:  rdata = STAT_VALUE;
                A_LOCK:  rdata = {15'b0, unlocked, lock_q};
                A_AUX:   rdata = aux_q;
                A_SDRAM: rdata = sdram_q;
                A_INIT:  rdata = init_q;
                A_FLG_S: rdata = flg_q;
                A_NVF_S: rdata = nvf_q;
                A_I_MSK: rdata = raw & ien;
                A_I_RAW: rdata = raw;
                A_I_ENS: rdata = ien;
                A_SW_S:  rdata = {31'b0, raw[0]};
                A_F_MSK: rdata = raw & fen;
                A_F_RAW: rdata = raw;
                A_F_ENS: rdata = fen;
                default: rd_ok = 1'b0;
            endcase
        end
    end

    always_comb begin
        case (req.word)
            A_OSC, A_CTRL, A_LOCK, A_AUX, A_SDRAM, A_INIT,
            A_FLG_S, A_FLG_C, A_NVF_S, A_NVF_C,
            A_I_ENS, A_I_ENC, A_SW_S, A_SW_C, A_F_ENS, A_F_ENC: wr_ok = 1'b1;
            default: wr_ok = volt_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdram_q   <= SDRAM_INIT;
            init_q    <= INIT_INIT;
            ctrl_q    <= '0;
            reset_req <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (wr_hit(req, A_SDRAM)) sdram_q <= req.data;
            if (wr_hit(req, A_INIT))  init_q  <= req.data;
            if (wr_hit(req, A_CTRL))  ctrl_q  <= '{remap: req.data[2], led: req.data[0]};
            reset_req <= wr_hit(req, A_CTRL) && req.data[3];
            err       <= (req.wr && !wr_ok) || (req.rd && !rd_ok);
        end
    end

    assign remap_sel = ctrl_q.remap;
    assign led       = ctrl_q.led;

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> ($past(wr_en) && ($past(word_addr) == A_CTRL) && $past(wdata[3]))); // R11
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(wr_en || rd_en)); // R12
    AST_KEY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (word_addr == A_LOCK)) |-> (rdata[16] == (rdata[15:0] == UNLOCK_KEY))); // R3
endmodule

// File: tb/board_ctl_regs_test.sv
module board_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  word_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err, irq, fiq, remap_sel, led, reset_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    board_ctl_regs uut (
        .clk(clk), .rst(rst), .word_addr(word_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .err(err), .irq(irq), .fiq(fiq),
        .remap_sel(remap_sel), .led(led), .reset_req(reset_req));

    typedef struct packed {
        logic        wr;
        logic [3:0]  req;
        logic [9:0]  a;
        logic [31:0] d;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd1,  10'd0,   32'h411A3001},  // R1 identity
        '{1'b0, 4'd1,  10'd1,   32'h00000000},  // R1
        '{1'b0, 4'd1,  10'd4,   32'h00100000},  // R1 status
        '{1'b0, 4'd1,  10'd32,  32'h00000000},  // R1 voltage
        '{1'b1, 4'd1,  10'd33,  32'hFFFFFFFF},  // R1 write ignored
        '{1'b0, 4'd1,  10'd33,  32'h00000000},  // R1
        '{1'b0, 4'd2,  10'd2,   32'h01000048},  // R2
        '{1'b0, 4'd2,  10'd7,   32'h0007FEFF},  // R2
        '{1'b0, 4'd2,  10'd9,   32'h00000112},  // R2
        '{1'b0, 4'd2,  10'd8,   32'h0001112E},  // R2 size code for 128
        '{1'b0, 4'd3,  10'd5,   32'h00000000},  // R3
        '{1'b1, 4'd4,  10'd2,   32'h12345678},  // R4 locked
        '{1'b0, 4'd4,  10'd2,   32'h01000048},  // R4
        '{1'b1, 4'd4,  10'd7,   32'h00000000},  // R4 locked
        '{1'b0, 4'd4,  10'd7,   32'h0007FEFF},  // R4
        '{1'b1, 4'd3,  10'd5,   32'hFFFFA05F},  // R3 key
        '{1'b0, 4'd3,  10'd5,   32'h0001A05F},  // R3
        '{1'b1, 4'd4,  10'd2,   32'h12345678},  // R4 unlocked
        '{1'b0, 4'd4,  10'd2,   32'h12345678},  // R4
        '{1'b1, 4'd4,  10'd7,   32'hAABBCCDD},  // R4
        '{1'b0, 4'd4,  10'd7,   32'hAABBCCDD},  // R4
        '{1'b1, 4'd3,  10'd5,   32'h00012345},  // R3 relock
        '{1'b0, 4'd3,  10'd5,   32'h00002345},  // R3
        '{1'b1, 4'd4,  10'd2,   32'h00000000},  // R4
        '{1'b0, 4'd4,  10'd2,   32'h12345678},  // R4
        '{1'b1, 4'd5,  10'd8,   32'hDEADBEEF},  // R5
        '{1'b0, 4'd5,  10'd8,   32'hDEADBEEF},  // R5
        '{1'b1, 4'd5,  10'd9,   32'h0000CAFE},  // R5
        '{1'b0, 4'd5,  10'd9,   32'h0000CAFE},  // R5
        '{1'b1, 4'd6,  10'd12,  32'h0000F0F0},  // R6
        '{1'b1, 4'd6,  10'd12,  32'h00000F00},  // R6
        '{1'b0, 4'd6,  10'd12,  32'h0000FFF0},  // R6
        '{1'b1, 4'd6,  10'd13,  32'h000000F0},  // R6
        '{1'b0, 4'd6,  10'd12,  32'h0000FF00},  // R6
        '{1'b1, 4'd6,  10'd14,  32'h00000005},  // R6
        '{1'b1, 4'd6,  10'd15,  32'h00000001},  // R6
        '{1'b0, 4'd6,  10'd14,  32'h00000004},  // R6
        '{1'b1, 4'd7,  10'd18,  32'h0000000F},  // R7
        '{1'b1, 4'd7,  10'd19,  32'h00000006},  // R7
        '{1'b0, 4'd7,  10'd18,  32'h00000009},  // R7
        '{1'b1, 4'd7,  10'd26,  32'h00000003},  // R7
        '{1'b1, 4'd7,  10'd27,  32'h00000001},  // R7
        '{1'b0, 4'd7,  10'd26,  32'h00000002},  // R7
        '{1'b1, 4'd8,  10'd20,  32'h000000FE},  // R8 bit0 clear: no effect
        '{1'b0, 4'd8,  10'd17,  32'h00000000},  // R8
        '{1'b1, 4'd8,  10'd20,  32'h00000001},  // R8
        '{1'b0, 4'd8,  10'd17,  32'h00000001},  // R8
        '{1'b0, 4'd8,  10'd16,  32'h00000001},  // R8
        '{1'b0, 4'd8,  10'd24,  32'h00000000},  // R8
        '{1'b0, 4'd8,  10'd25,  32'h00000001},  // R8
        '{1'b1, 4'd8,  10'd21,  32'h000000FE},  // R8 no effect
        '{1'b0, 4'd8,  10'd20,  32'h00000001},  // R8
        '{1'b1, 4'd8,  10'd21,  32'h00000001},  // R8
        '{1'b0, 4'd8,  10'd17,  32'h00000000},  // R8
        '{1'b0, 4'd10, 10'd64,  32'h00000080},  // R10
        '{1'b0, 4'd10, 10'd73,  32'h000000A0},  // R10
        '{1'b0, 4'd10, 10'd95,  32'h00000020},  // R10
        '{1'b0, 4'd10, 10'd96,  32'h00000000},  // R10
        '{1'b1, 4'd10, 10'd64,  32'h000000FF},  // R10 write ignored
        '{1'b0, 4'd10, 10'd64,  32'h00000080}   // R10
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        word_addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        word_addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R9 R11 R12)
        check(irq == 1'b0, "R9 irq after reset", {31'b0, irq}, 0);
        check(fiq == 1'b0, "R9 fiq after reset", {31'b0, fiq}, 0);
        check(led == 1'b0 && remap_sel == 1'b0, "R11 ctrl after reset", {30'b0, remap_sel, led}, 0);
        check(reset_req == 1'b0, "R11 reset_req after reset", {31'b0, reset_req}, 0);
        check(err == 1'b0, "R12 err after reset", {31'b0, err}, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].a, VEC[i].d);
            end else begin
                do_read(VEC[i].a, v);
                check(v == VEC[i].d, $sformatf("R%0d vector %0d word %0d", VEC[i].req, i, VEC[i].a), v, VEC[i].d);
            end
        end

        // R11: led, remap select, readback, reset pulse
        do_write(10'd3, 32'h5);
        check(led == 1'b1 && remap_sel == 1'b1, "R11 led/remap set", {30'b0, remap_sel, led}, 32'h3);
        do_read(10'd3, v);
        check(v == 32'h5, "R11 ctrl readback", v, 32'h5);
        do_write(10'd3, 32'h0);
        check(led == 1'b0 && remap_sel == 1'b0, "R11 led/remap clear", {30'b0, remap_sel, led}, 0);
        check(reset_req == 1'b0, "R11 no reset without bit3", {31'b0, reset_req}, 0);
        do_write(10'd3, 32'h8);
        check(reset_req == 1'b1, "R11 reset pulse", {31'b0, reset_req}, 1);
        @(negedge clk);
        check(reset_req == 1'b0, "R11 reset pulse width", {31'b0, reset_req}, 0);

        // R9: interrupt pins (IRQ enable bit0 still set, FIQ enables 0x2)
        do_write(10'd20, 32'h1);
        check(irq == 1'b1, "R9 irq on", {31'b0, irq}, 1);
        check(fiq == 1'b0, "R9 fiq masked", {31'b0, fiq}, 0);
        do_write(10'd26, 32'h1);
        check(fiq == 1'b1, "R9 fiq on", {31'b0, fiq}, 1);
        do_write(10'd19, 32'h1);
        check(irq == 1'b0, "R9 irq masked off", {31'b0, irq}, 0);
        do_write(10'd27, 32'hFFFFFFFF);
        check(fiq == 1'b0, "R9 fiq masked off", {31'b0, fiq}, 0);
        do_write(10'd21, 32'h1);

        // R12: unmapped accesses
        do_read(10'd6, v);
        check(v == 32'h0, "R12 unmapped read data", v, 0);
        check(err == 1'b1, "R12 err after bad read", {31'b0, err}, 1);
        @(negedge clk);
        check(err == 1'b0, "R12 err one cycle", {31'b0, err}, 0);
        do_write(10'd0, 32'hFFFFFFFF);
        check(err == 1'b1, "R12 err after bad write", {31'b0, err}, 1);
        do_read(10'd0, v);
        check(v == 32'h411A3001, "R12 bad write no effect", v, 32'h411A3001);
        check(err == 1'b0, "R12 no err on good read", {31'b0, err}, 0);
        do_read(10'd13, v);
        check(err == 1'b1 && v == 32'h0, "R12 write-only word read", v, 0);

        finish_run();
    end

endmodule